// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 memory from power-on to a state in which it accepts ordinary traffic. After a start pulse it walks the memory's power-up procedure on its own, with no processor involvement. It drives a command slot (chip select, row strobe, column strobe, write enable), an address bus, a bank bus and the three static control lines (clock enable, on-die termination, memory reset) toward a PHY.

The procedure runs as follows. Reset is released with termination on and clock enable low, followed by a long wait. Clock enable is then raised, followed by a shorter wait. The four mode registers are loaded in the fixed order 2, 3, 1, 0, spaced by a minimum mode-register cycle time. After a settling wait, a long ZQ calibration is issued. A final wait follows, after which a sticky done flag rises. Every wait is a parameter counted in clock cycles. The mode register contents are fixed: write latency 5, read latency 6, burst length 8.

The command bits on the ports are active-high ("asserted"), so a PHY that drives the memory's active-low pins inverts them. Outputs are decoded from state registers only, so they change just after a clock edge and never combinationally from `start`.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, and afterwards until `start` is seen high at a rising clock edge, all outputs are 0. This covers `phy_reset_n`, `phy_cke`, `phy_odt`, the four command bits, `phy_addr`, `phy_bank` and `init_done`.
- R2: From the clock edge at which `start` is accepted, `phy_reset_n` and `phy_odt` are 1 and `phy_cke` is 0 for exactly `T_RST` cycles.
- R3: After the reset-release step, `phy_cke` is 1 for `T_CKE` cycles before the first command. From then on `phy_cke`, `phy_odt` and `phy_reset_n` stay 1 until reset.
- R4: A mode register load asserts all four command bits together (cs=ras=cas=we=1). The four loads go to bank 2, 3, 1 and 0 in that order, with address 0x200, 0x000, 0x006 and 0x320 respectively. The first load occurs in the cycle right after the `T_CKE` window.
- R5: Each command is driven for exactly one cycle. `phy_addr` and `phy_bank` are 0 on every cycle that carries no command. Consecutive mode register loads start exactly `T_MRD` cycles apart.
- R6: After the bank-0 load, `T_MOD` NOP cycles pass and then ZQ calibration is issued for one cycle. It has cs=1, we=1, ras=0, cas=0, address 0x400 (bit 10 set, long calibration) and bank 0.
- R7: `init_done` rises after `T_ZQ` NOP cycles following the ZQ calibration cycle, and stays 1 until `rst`.
- R8: `start` while the sequence runs, or after `init_done`, has no effect on any output.
- R9: Raising `rst` in the middle of the sequence returns all outputs to the R1 state at the next edge. A later `start` runs the complete sequence again from the reset-release step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| phy_cs | output | 1 | Chip select, active-high |
| phy_ras | output | 1 | Row strobe, active-high |
| phy_cas | output | 1 | Column strobe, active-high |
| phy_we | output | 1 | Write enable, active-high |
| phy_addr | output | ADDR_W | Command address |
| phy_bank | output | BANK_W | Command bank |
| phy_cke | output | 1 | Clock enable to memory |
| phy_odt | output | 1 | On-die termination |
| phy_reset_n | output | 1 | Memory reset, active-low |
| init_done | output | 1 | Sequence complete, sticky |

## Verification
The bench goes after the exact cycle boundaries of each wait. A timer that is off by one would shift the first mode register load, the ZQ cycle or the done edge by a cycle. The bench also checks the order and content of the four loads. A design with a wrong index decode would send the right values to the wrong banks, and one with a wrong gap would break the `T_MRD` spacing. A late `start` pulse is applied both mid-sequence and after completion, so a design that restarts would drop clock enable or done. Finally a reset is issued in the middle of the wait windows, to show that no timer or index state leaks into the rerun.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WAIT,
    ST_CKE_WAIT,
    ST_MRS,
    ST_MRD_GAP,
    ST_MOD_WAIT,
    ST_ZQ,
    ST_ZQ_WAIT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic cs;
    logic ras;
    logic cas;
    logic we;
  } cmd_bits_t;

  localparam logic [15:0] ZQ_LONG_ADDR = 16'h0400;

  // Load slot -> target bank: 2, 3, 1, 0
  function automatic logic [2:0] mrs_bank(input logic [1:0] slot);
    case (slot)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // Fixed contents: WL 5, CL 6, BL 8
  function automatic logic [15:0] mrs_value(input logic [2:0] bank);
    case (bank)
      3'd2:    return 16'h0200;
      3'd3:    return 16'h0000;
      3'd1:    return 16'h0006;
      3'd0:    return 16'h0320;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr3_seq_timer.sv
module ddr3_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/ddr3_cmd_encode.sv
module ddr3_cmd_encode
  import ddr3_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  seq_state_e        state,
  input  logic [1:0]        mr_slot,
  output cmd_bits_t         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              cke,
  output logic              odt,
  output logic              reset_n,
  output logic              done
);
  logic [2:0] slot_bank;
  assign slot_bank = mrs_bank(mr_slot);

  always_comb begin
    cmd     = '0;
    addr    = '0;
    bank    = '0;
    reset_n = (state != ST_IDLE);
    odt     = (state != ST_IDLE);
    cke     = (state != ST_IDLE) && (state != ST_RST_WAIT);
    done    = (state == ST_DONE);
    case (state)
      ST_MRS: begin
        cmd  = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
        bank = BANK_W'(slot_bank);
        addr = ADDR_W'(mrs_value(slot_bank));
      end
      ST_ZQ: begin
        cmd  = '{cs: 1'b1, ras: 1'b0, cas: 1'b0, we: 1'b1};
        addr = ADDR_W'(ZQ_LONG_ADDR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_init_pkg::*;
#(
  parameter int T_RST  = 50000,
  parameter int T_CKE  = 10000,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 200,
  parameter int T_ZQ   = 200,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              phy_cs,
  output logic              phy_ras,
  output logic              phy_cas,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [BANK_W-1:0] phy_bank,
  output logic              phy_cke,
  output logic              phy_odt,
  output logic              phy_reset_n,
  output logic              init_done
);
  localparam int MAX_WAIT = max_of(max_of(T_RST, T_CKE), max_of(max_of(T_MOD, T_ZQ), T_MRD));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [1:0] LAST_SLOT = 2'd3;

  seq_state_e       state, state_nxt;
  logic [1:0]       mr_slot, mr_slot_nxt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  cmd_bits_t        cmd;

  // Named internal events
  logic step_done;
  logic start_accept;
  logic mrs_issue;
  logic zq_issue;
  logic last_mrs;

  assign start_accept = (state == ST_IDLE) && start;
  assign mrs_issue    = (state == ST_MRS);
  assign zq_issue     = (state == ST_ZQ);
  assign last_mrs     = mrs_issue && (mr_slot == LAST_SLOT);

  ddr3_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (step_done)
  );

  always_comb begin
    state_nxt   = state;
    mr_slot_nxt = mr_slot;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    case (state)
      ST_IDLE: if (start_accept) begin
        state_nxt = ST_RST_WAIT;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(T_RST - 1);
      end
      ST_RST_WAIT: if (step_done) begin
        state_nxt = ST_CKE_WAIT;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(T_CKE - 1);
      end
      ST_CKE_WAIT: if (step_done) begin
        state_nxt   = ST_MRS;
        mr_slot_nxt = '0;
      end
      ST_MRS: begin
        tmr_load = 1'b1;
        if (last_mrs) begin
          state_nxt = ST_MOD_WAIT;
          tmr_val   = CNT_W'(T_MOD - 1);
        end else begin
          state_nxt = ST_MRD_GAP;
          tmr_val   = CNT_W'(T_MRD - 2);
        end
      end
      ST_MRD_GAP: if (step_done) begin
        state_nxt   = ST_MRS;
        mr_slot_nxt = 2'(mr_slot + 2'd1);
      end
      ST_MOD_WAIT: if (step_done) state_nxt = ST_ZQ;
      ST_ZQ: begin
        state_nxt = ST_ZQ_WAIT;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(T_ZQ - 1);
      end
      ST_ZQ_WAIT: if (step_done) state_nxt = ST_DONE;
      ST_DONE: state_nxt = ST_DONE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mr_slot <= '0;
    end else begin
      state   <= state_nxt;
      mr_slot <= mr_slot_nxt;
    end
  end

  ddr3_cmd_encode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_enc (
    .state   (state),
    .mr_slot (mr_slot),
    .cmd     (cmd),
    .addr    (phy_addr),
    .bank    (phy_bank),
    .cke     (phy_cke),
    .odt     (phy_odt),
    .reset_n (phy_reset_n),
    .done    (init_done)
  );

  assign phy_cs  = cmd.cs;
  assign phy_ras = cmd.ras;
  assign phy_cas = cmd.cas;
  assign phy_we  = cmd.we;
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk
  import ddr3_init_pkg::*;
#(
  parameter int T_MRD  = 4,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              phy_cs,
  input logic              phy_ras,
  input logic              phy_cas,
  input logic              phy_we,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [BANK_W-1:0] phy_bank,
  input logic              phy_cke,
  input logic              phy_odt,
  input logic              phy_reset_n,
  input logic              init_done,
  input logic              start_accept,
  input logic              mrs_issue,
  input logic              zq_issue
);
  localparam int GAP_W = $clog2(T_MRD + 1);

  logic             mrs_cmd, zq_cmd, seen_mrs;
  logic [GAP_W-1:0] since_mrs;
  logic [BANK_W-1:0] last_bank;
  logic [BANK_W-1:0] want_bank;

  assign mrs_cmd = phy_cs && phy_ras && phy_cas && phy_we;
  assign zq_cmd  = phy_cs && phy_we && !phy_ras && !phy_cas;

  always_comb begin
    case (last_bank)
      BANK_W'(2): want_bank = BANK_W'(3);
      BANK_W'(3): want_bank = BANK_W'(1);
      default:    want_bank = BANK_W'(0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_mrs  <= 1'b0;
      since_mrs <= '0;
      last_bank <= '0;
    end else if (mrs_cmd) begin
      seen_mrs  <= 1'b1;
      since_mrs <= '0;
      last_bank <= phy_bank;
    end else if (int'(since_mrs) < T_MRD) begin
      since_mrs <= since_mrs + 1'b1;
    end
  end

  // R1: before acceptance nothing is driven
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !phy_reset_n |-> !phy_cke && !phy_odt && !phy_cs && !init_done && phy_addr == '0);

  // R2: acceptance releases reset with CKE low
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    start_accept |=> phy_reset_n && phy_odt && !phy_cke);

  // R3: CKE implies termination and reset released, and CKE stays up
  a_r3_cke_hold: assert property (@(posedge clk) disable iff (rst)
    phy_cke |=> phy_cke && phy_odt && phy_reset_n);

  // R4: load content matches bank, order follows 2,3,1,0
  a_r4_mrs_value: assert property (@(posedge clk) disable iff (rst)
    mrs_cmd |-> phy_cke && phy_addr == ADDR_W'(mrs_value(3'(phy_bank))));
  a_r4_mrs_order: assert property (@(posedge clk) disable iff (rst)
    (mrs_cmd && seen_mrs) |-> phy_bank == want_bank);
  a_r4_issue_match: assert property (@(posedge clk) disable iff (rst)
    mrs_issue |-> mrs_cmd);

  // R5: single-cycle commands, idle bus, tMRD spacing
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    phy_cs |=> !phy_cs);
  a_r5_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !phy_cs |-> phy_addr == '0 && phy_bank == '0);
  a_r5_mrd_gap: assert property (@(posedge clk) disable iff (rst)
    (mrs_cmd && seen_mrs) |-> int'(since_mrs) >= T_MRD - 1);

  // R6: ZQ long calibration encoding
  a_r6_zq_form: assert property (@(posedge clk) disable iff (rst)
    zq_issue |-> zq_cmd && phy_addr == ADDR_W'(ZQ_LONG_ADDR) && phy_bank == '0);

  // R7 / R8: done is sticky whatever start does
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done && !phy_cs);
  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && phy_cke) |=> phy_cke);
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(
  .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .phy_cs(phy_cs), .phy_ras(phy_ras), .phy_cas(phy_cas), .phy_we(phy_we),
  .phy_addr(phy_addr), .phy_bank(phy_bank), .phy_cke(phy_cke),
  .phy_odt(phy_odt), .phy_reset_n(phy_reset_n), .init_done(init_done),
  .start_accept(start_accept), .mrs_issue(mrs_issue), .zq_issue(zq_issue)
);

// File: tb/ddr3_pwrup_seq_bench.sv
module ddr3_pwrup_seq_bench;
  localparam int T_RST = 40;
  localparam int T_CKE = 20;
  localparam int T_MRD = 4;
  localparam int T_MOD = 10;
  localparam int T_ZQ  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cs, ras, cas, we, cke, odt, reset_n, done;
  logic [13:0] addr;
  logic [2:0]  bank;

  always #10 clk = ~clk;

  ddr3_pwrup_seq #(
    .T_RST(T_RST), .T_CKE(T_CKE), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQ(T_ZQ),
    .ADDR_W(14), .BANK_W(3)
  ) u_ddr3_pwrup_seq (
    .clk(clk), .rst(rst), .start(start),
    .phy_cs(cs), .phy_ras(ras), .phy_cas(cas), .phy_we(we),
    .phy_addr(addr), .phy_bank(bank), .phy_cke(cke), .phy_odt(odt),
    .phy_reset_n(reset_n), .init_done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;
  bit started = 0;
  int t = 0;
  string tag_force = "";

  // Reference: cycle count since acceptance
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      started = 0; t = 0;
    end else if (!started) begin
      if (start) begin started = 1; t = 0; end
    end else begin
      t = t + 1;
    end
  end

  // packed: done, reset_n, cke, odt, cs, ras, cas, we, bank[3], addr[14]
  function automatic logic [24:0] model(input bit s, input int tt);
    logic [24:0] v = '0;
    int u, k;
    if (!s) return v;
    v[23] = 1'b1; v[21] = 1'b1;
    if (tt < T_RST) return v;
    v[22] = 1'b1;
    u = tt - T_RST - T_CKE;
    if (u < 0) return v;
    if (u < 4 * T_MRD && (u % T_MRD) == 0) begin
      k = u / T_MRD;
      v[20:17] = 4'b1111;
      case (k)
        0: begin v[16:14] = 3'd2; v[13:0] = 14'h200; end
        1: begin v[16:14] = 3'd3; v[13:0] = 14'h000; end
        2: begin v[16:14] = 3'd1; v[13:0] = 14'h006; end
        default: begin v[16:14] = 3'd0; v[13:0] = 14'h320; end
      endcase
    end else if (u == 3 * T_MRD + T_MOD + 1) begin
      v[20:17] = 4'b1001;
      v[13:0]  = 14'h400;
    end else if (u >= 3 * T_MRD + T_MOD + 2 + T_ZQ) begin
      v[24] = 1'b1;
    end
    return v;
  endfunction

  always @(negedge clk) begin
    logic [24:0] exp_v, act_v;
    string tag;
    if (!finished) begin
      exp_v = model(started, t);
      act_v = {done, reset_n, cke, odt, cs, ras, cas, we, bank, addr};
      if (tag_force != "") tag = tag_force;
      else if (!started) tag = "R1";
      else if (exp_v[20:17] == 4'b1111) tag = "R4";
      else if (exp_v[20:17] == 4'b1001) tag = "R6";
      else if (exp_v[24]) tag = "R7";
      else if (!exp_v[22]) tag = "R2";
      else if (t < T_RST + T_CKE) tag = "R3";
      else tag = "R5";
      vectors = vectors + 1;
      if (act_v !== exp_v) begin
        miscompares = miscompares + 1;
        $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act_v, exp_v);
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!finished && cycles > 20000) begin
      finished = 1;
      miscompares = miscompares + 1;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset and idle quiet
    tag_force = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    tag_force = "";
    // R2..R7: full run
    pulse_start();
    repeat (10) @(negedge clk);
    // R8: start during the reset-release wait
    tag_force = "R8";
    pulse_start();
    repeat (T_RST + 3) @(negedge clk);
    pulse_start();
    tag_force = "";
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);
    // R8: start after done
    tag_force = "R8";
    pulse_start();
    repeat (8) @(negedge clk);
    // R9: reset in mid sequence then rerun
    tag_force = "R9";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (T_RST + 5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    pulse_start();
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    tag_force = "";
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule